// File: doc/BRIEF.md
# Configuration Request PIO Engine

This block lets software issue one PCIe configuration read or write at a time through a small register file. Software first sets a transaction type in the control register and writes the target address word, the write data and a byte-enable mask. It then clears the interrupt status and writes 1 to the start register. The engine copies these fields, presents a single request to the downstream link and waits for the completion. When the transfer ends, the start bit falls back to 0 and the interrupt status bit is set. The status register then holds a 3-bit completion code, a non-posted flag and a completion-error flag.

The link side has two valid/ready channels. On the request channel the engine holds `req_valid` and every request field steady until `req_ready` is seen at a clock edge. The one exception is a timeout: it withdraws the request before that handshake. On the response channel the engine raises `rsp_ready` only while it is waiting for a completion. The link may hold `rsp_valid` for as long as it needs, and the completion is taken on the edge where both signals are high. A programmable timeout finishes a transfer that gets no answer and reports an abort.

Register word addresses: 0 control, 1 status (read only), 2 address, 3 write data, 4 byte mask, 5 read data (read only), 6 start, 7 interrupt status, 8 timeout limit. Writes take effect at the clock edge. Reads are combinational from `reg_raddr`.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset, start, interrupt status, status and read data all read 0, `irq` is low and `req_valid` is low.
- R2: Writing 1 in bit 0 of start while idle makes start read 1 and issues exactly one request. The request carries the type from control bits 3:0 and the stored address word. `req_nowin` is a copy of control bit 24 (address-window bypass).
- R3: The address register keeps bits 27:2 as written: bus in 27:20, device in 19:15, function in 14:12, dword offset in 11:2. Bits 31:28 and 1:0 always read 0.
- R4: Write types (0xA Type0, 0xB Type1) send the programmed 4-bit byte mask and the write data. Read types (0x8 Type0, 0x9 Type1) always send mask 0xF.
- R5: When the completion handshake occurs, start reads 0 from the next cycle on, interrupt status bit 0 is set and `irq` goes high.
- R6: On completion the status register holds the completion code in bits 9:7 (0 OK, 1 unsupported request, 2 retry status, 4 completer abort). Bit 10 shows the request was non-posted and bit 11 shows a completion error.
- R7: The read-data register is loaded only when a read completes with code 0 and no error flag. All other completions, and all write completions, leave it unchanged.
- R8: A write to start while a transfer is in flight is ignored: start stays 1 and no second request appears.
- R9: Writing 1 to interrupt status bit 0 clears it and drops `irq`. Writing 0 leaves it set.
- R10: With a nonzero timeout limit L, a transfer still without a completion after L busy cycles finishes with code 4 and the error flag set. This holds whether it was waiting for request acceptance or for the response. A limit of 0 disables the timeout.
- R11: A type outside 0x8 to 0xB issues no request and finishes with code 1, non-posted flag 0 and error flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read word address |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | High while interrupt status is set |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Link accepts the request |
| req_type | output | 4 | Transaction type |
| req_addr | output | 32 | Configuration address word |
| req_data | output | 32 | Write data |
| req_strobe | output | 4 | Byte mask |
| req_nowin | output | 1 | Bypass outbound address-window translation |
| rsp_valid | input | 1 | Completion valid |
| rsp_ready | output | 1 | Engine waiting for a completion |
| rsp_code | input | 3 | Completion status code |
| rsp_err | input | 1 | Completion error flag |
| rsp_data | input | 32 | Completion read data |

## Verification
The hardest states to reach are a timeout while the request is still unaccepted and a second start while the engine is busy. Both require the link to stall for a controlled number of cycles. The link model in the bench has per-transfer knobs for acceptance latency, response latency and silence. These are set longer than the programmed limit, or long enough to leave a window in which a second start is written and start is read back. A scoreboard queue flags any request the driver did not expect, so a withdrawn or duplicated request is reported as a failure.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;
  localparam int DW     = 32;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] RA_STAT  = 4'd1;
  localparam logic [REG_AW-1:0] RA_ADDR  = 4'd2;
  localparam logic [REG_AW-1:0] RA_WDATA = 4'd3;
  localparam logic [REG_AW-1:0] RA_STRB  = 4'd4;
  localparam logic [REG_AW-1:0] RA_RDATA = 4'd5;
  localparam logic [REG_AW-1:0] RA_START = 4'd6;
  localparam logic [REG_AW-1:0] RA_ISR   = 4'd7;
  localparam logic [REG_AW-1:0] RA_TMO   = 4'd8;

  localparam logic [2:0] CC_OK  = 3'd0;
  localparam logic [2:0] CC_UR  = 3'd1;
  localparam logic [2:0] CC_CRS = 3'd2;
  localparam logic [2:0] CC_CA  = 3'd4;

  localparam int CTRL_NOWIN_BIT = 24;
  localparam logic [DW-1:0] ADDR_KEEP = 32'h0FFF_FFFC;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_REJECT} seq_state_e;

  typedef struct packed {
    logic [2:0]    code;
    logic          err;
    logic          np;
    logic          is_read;
    logic [DW-1:0] data;
  } cpl_t;

  function automatic logic type_is_cfg(input logic [3:0] t);
    return t[3:2] == 2'b10;
  endfunction

  function automatic logic type_is_read(input logic [3:0] t);
    return type_is_cfg(t) && !t[1];
  endfunction
endpackage

// File: rtl/cfg_pio_timer.sv
module cfg_pio_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (limit != '0) && (cnt_q >= limit);
endmodule

// File: rtl/cfg_pio_seq.sv
module cfg_pio_seq
  import cfg_pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [3:0]    ctrl_type,
  input  logic          ctrl_nowin,
  input  logic [DW-1:0] addr_word,
  input  logic [DW-1:0] wdata,
  input  logic [3:0]    strb,
  input  logic          tmo_expire,
  output logic          busy,
  output logic          run,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [3:0]    req_type,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic [3:0]    req_strobe,
  output logic          req_nowin,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [2:0]    rsp_code,
  input  logic          rsp_err,
  input  logic [DW-1:0] rsp_data,
  output logic          done,
  output cpl_t          cpl
);
  seq_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      req_type   <= '0;
      req_addr   <= '0;
      req_data   <= '0;
      req_strobe <= '0;
      req_nowin  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch && state_q == S_IDLE) begin
        req_type   <= ctrl_type;
        req_addr   <= addr_word;
        req_data   <= wdata;
        req_strobe <= type_is_read(ctrl_type) ? 4'hF : strb;
        req_nowin  <= ctrl_nowin;
      end
    end
  end

  assign busy      = state_q != S_IDLE;
  assign run       = (state_q == S_ISSUE) || (state_q == S_WAIT);
  assign req_valid = (state_q == S_ISSUE) && !tmo_expire;
  assign rsp_ready = state_q == S_WAIT;

  always_comb begin
    state_d     = state_q;
    done        = 1'b0;
    cpl.code    = CC_OK;
    cpl.err     = 1'b0;
    cpl.np      = 1'b1;
    cpl.is_read = type_is_read(req_type);
    cpl.data    = rsp_data;
    case (state_q)
      S_IDLE: begin
        if (launch) state_d = type_is_cfg(ctrl_type) ? S_ISSUE : S_REJECT;
      end
      S_ISSUE: begin
        if (tmo_expire) begin
          done     = 1'b1;
          cpl.code = CC_CA;
          cpl.err  = 1'b1;
          state_d  = S_IDLE;
        end else if (req_ready) begin
          state_d = S_WAIT;
        end
      end
      S_WAIT: begin
        if (rsp_valid) begin
          done     = 1'b1;
          cpl.code = rsp_code;
          cpl.err  = rsp_err;
          state_d  = S_IDLE;
        end else if (tmo_expire) begin
          done     = 1'b1;
          cpl.code = CC_CA;
          cpl.err  = 1'b1;
          state_d  = S_IDLE;
        end
      end
      S_REJECT: begin
        done     = 1'b1;
        cpl.code = CC_UR;
        cpl.np   = 1'b0;
        state_d  = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid || tmo_expire || !busy)); // R2
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R5
  AST_REJECT_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy && !type_is_cfg(ctrl_type)) |=> !req_valid); // R11
endmodule

// File: rtl/cfg_pio_regs.sv
module cfg_pio_regs
  import cfg_pio_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [DW-1:0]     reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  cpl_t              cpl,
  output logic              launch,
  output logic [DW-1:0]     ctrl_q,
  output logic [DW-1:0]     addr_q,
  output logic [DW-1:0]     wdata_q,
  output logic [3:0]        strb_q,
  output logic [TMO_W-1:0]  tmo_q,
  output logic              irq
);
  localparam int TMO_PAD = DW - TMO_W;

  logic [2:0]    code_q;
  logic          np_q;
  logic          err_q;
  logic [DW-1:0] rdata_q;
  logic          isr_q;

  logic wr_hit_start, wr_hit_isr;
  assign wr_hit_start = reg_we && (reg_waddr == RA_START);
  assign wr_hit_isr   = reg_we && (reg_waddr == RA_ISR);
  assign launch       = wr_hit_start && reg_wdata[0] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      strb_q  <= '0;
      tmo_q   <= '0;
    end else if (reg_we) begin
      case (reg_waddr)
        RA_CTRL:  ctrl_q  <= reg_wdata;
        RA_ADDR:  addr_q  <= reg_wdata & ADDR_KEEP;
        RA_WDATA: wdata_q <= reg_wdata;
        RA_STRB:  strb_q  <= reg_wdata[3:0];
        RA_TMO:   tmo_q   <= reg_wdata[TMO_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= CC_OK;
      np_q    <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      isr_q   <= 1'b0;
    end else begin
      if (done) begin
        code_q <= cpl.code;
        np_q   <= cpl.np;
        err_q  <= cpl.err;
        if (cpl.is_read && cpl.code == CC_OK && !cpl.err) rdata_q <= cpl.data;
      end
      if (done) isr_q <= 1'b1;
      else if (wr_hit_isr && reg_wdata[0]) isr_q <= 1'b0;
    end
  end

  assign irq = isr_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      RA_CTRL:  reg_rdata = ctrl_q;
      RA_STAT:  reg_rdata = {{(DW-12){1'b0}}, err_q, np_q, code_q, 7'd0};
      RA_ADDR:  reg_rdata = addr_q;
      RA_WDATA: reg_rdata = wdata_q;
      RA_STRB:  reg_rdata = {{(DW-4){1'b0}}, strb_q};
      RA_RDATA: reg_rdata = rdata_q;
      RA_START: reg_rdata = {{(DW-1){1'b0}}, busy};
      RA_ISR:   reg_rdata = {{(DW-1){1'b0}}, isr_q};
      RA_TMO:   reg_rdata = {{TMO_PAD{1'b0}}, tmo_q};
      default:  reg_rdata = '0;
    endcase
  end

  AST_ISR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> isr_q); // R5
  AST_RDATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && cpl.is_read && cpl.code == CC_OK && !cpl.err) |=> $stable(rdata_q)); // R7
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q[1:0] == 2'b00) && (addr_q[31:28] == 4'h0)); // R3
  AST_ISR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q && !(wr_hit_isr && reg_wdata[0])) |=> isr_q); // R9
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
  import cfg_pio_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [3:0]        req_type,
  output logic [DW-1:0]     req_addr,
  output logic [DW-1:0]     req_data,
  output logic [3:0]        req_strobe,
  output logic              req_nowin,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [2:0]        rsp_code,
  input  logic              rsp_err,
  input  logic [DW-1:0]     rsp_data
);
  logic             launch, busy, run, done, expire;
  cpl_t             cpl;
  logic [DW-1:0]    ctrl_q, addr_q, wdata_q;
  logic [3:0]       strb_q;
  logic [TMO_W-1:0] tmo_q;

  cfg_pio_regs #(.TMO_W(TMO_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .cpl(cpl),
    .launch(launch), .ctrl_q(ctrl_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .strb_q(strb_q), .tmo_q(tmo_q), .irq(irq)
  );

  cfg_pio_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .limit(tmo_q), .expire(expire)
  );

  cfg_pio_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .ctrl_type(ctrl_q[3:0]), .ctrl_nowin(ctrl_q[CTRL_NOWIN_BIT]),
    .addr_word(addr_q), .wdata(wdata_q), .strb(strb_q), .tmo_expire(expire),
    .busy(busy), .run(run),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_addr(req_addr), .req_data(req_data), .req_strobe(req_strobe),
    .req_nowin(req_nowin),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_err(rsp_err), .rsp_data(rsp_data),
    .done(done), .cpl(cpl)
  );
endmodule

// File: tb/cfg_pio_engine_test.sv
`timescale 1ns/1ps
module cfg_pio_engine_test;
  import cfg_pio_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, reg_we, irq, req_valid, req_ready, req_nowin, rsp_valid, rsp_ready, rsp_err;
  logic [3:0] reg_waddr, reg_raddr, req_type, req_strobe;
  logic [31:0] reg_wdata, reg_rdata, req_addr, req_data, rsp_data;
  logic [2:0] rsp_code;

  cfg_pio_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_addr(req_addr), .req_data(req_data), .req_strobe(req_strobe),
    .req_nowin(req_nowin), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_code(rsp_code), .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  bit reported = 0;

  typedef struct {
    logic [3:0]  ty;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic        nowin;
  } req_exp_t;
  req_exp_t exp_q[$];

  int          lk_req_lat = 0;
  int          lk_rsp_lat = 0;
  bit          lk_silent  = 0;
  logic [2:0]  lk_code    = 3'd0;
  logic        lk_err     = 1'b0;
  logic [31:0] lk_data    = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_raddr = a;
    #1 v = reg_rdata;
  endtask

  task automatic set_link(input int rq, input int rs, input bit sil,
                          input logic [2:0] c, input logic e, input logic [31:0] d);
    lk_req_lat = rq; lk_rsp_lat = rs; lk_silent = sil;
    lk_code = c; lk_err = e; lk_data = d;
  endtask

  // Link model and scoreboard monitor: every accepted request is popped and compared.
  task automatic compare_req();
    req_exp_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R8 unexpected request", {28'd0, req_type}, 32'd0);
    end else begin
      e = exp_q.pop_front();
      chk(req_type == e.ty, "R2 request type", {28'd0, req_type}, {28'd0, e.ty});
      chk(req_addr == e.addr, "R3 request address", req_addr, e.addr);
      chk(req_strobe == e.strb, "R4 request strobe", {28'd0, req_strobe}, {28'd0, e.strb});
      chk(req_data == e.data, "R4 request data", req_data, e.data);
      chk(req_nowin == e.nowin, "R2 window bypass", {31'd0, req_nowin}, {31'd0, e.nowin});
    end
  endtask

  initial begin
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_code = '0; rsp_err = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        for (int h = lk_req_lat; h > 0 && req_valid; h--) @(negedge clk);
        if (req_valid) begin
          req_ready = 1'b1;
          compare_req();
          @(negedge clk);
          req_ready = 1'b0;
          if (!lk_silent) begin
            for (int h = lk_rsp_lat; h > 0 && rsp_ready; h--) @(negedge clk);
            if (rsp_ready) begin
              rsp_valid = 1'b1; rsp_code = lk_code; rsp_err = lk_err; rsp_data = lk_data;
              @(negedge clk);
              rsp_valid = 1'b0;
            end
          end
        end
      end
    end
  end

  task automatic launch(input logic [3:0] ty, input logic [31:0] araw, input logic [31:0] wd,
                        input logic [3:0] sb, input bit nw, input int lim, input bit expect_req);
    req_exp_t e;
    if (expect_req) begin
      e.ty = ty; e.addr = araw & 32'h0FFF_FFFC; e.data = wd;
      e.strb = ty[1] ? sb : 4'hF; e.nowin = nw;
      exp_q.push_back(e);
    end
    wr(RA_CTRL, {7'd0, nw, 20'd0, ty});
    wr(RA_ADDR, araw);
    wr(RA_WDATA, wd);
    wr(RA_STRB, {28'd0, sb});
    wr(RA_TMO, lim);
    wr(RA_ISR, 32'd1);
    wr(RA_START, 32'd1);
  endtask

  task automatic finish_xfer(input string tag, input logic [2:0] code, input logic err,
                             input logic np, input logic [31:0] rdata);
    logic [31:0] v, exp_stat;
    for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
    chk(irq, {tag, " R5 irq"}, {31'd0, irq}, 32'd1);
    rd(RA_START, v); chk(v == 32'd0, {tag, " R5 start cleared"}, v, 32'd0);
    rd(RA_ISR, v);   chk(v == 32'd1, {tag, " R5 isr set"}, v, 32'd1);
    exp_stat = {20'd0, err, np, code, 7'd0};
    rd(RA_STAT, v);  chk(v == exp_stat, {tag, " R6 status"}, v, exp_stat);
    rd(RA_RDATA, v); chk(v == rdata, {tag, " R7 read data"}, v, rdata);
    chk(exp_q.size() == 0, {tag, " R2 request issued"}, exp_q.size(), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 32'd0, 32'd1);
    report();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] a1;
    rst_n = 1'b0; reg_we = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(RA_START, v); chk(v == 0, "R1 start", v, 0);
    rd(RA_ISR, v);   chk(v == 0, "R1 isr", v, 0);
    rd(RA_STAT, v);  chk(v == 0, "R1 status", v, 0);
    rd(RA_RDATA, v); chk(v == 0, "R1 read data", v, 0);
    chk(!irq && !req_valid, "R1 irq/req_valid", {30'd0, irq, req_valid}, 0);

    // R2 R3 R4 R7: Type0 read, low address bits and high nibble set
    a1 = 32'hF000_0000 | (32'd1 << 20) | (32'd3 << 15) | (32'd2 << 12) | 32'h013;
    set_link(0, 2, 0, CC_OK, 1'b0, 32'hCAFE_0001);
    launch(4'h8, a1, 32'h1111_2222, 4'h3, 1'b0, 0, 1);
    rd(RA_ADDR, v); chk(v == (a1 & 32'h0FFF_FFFC), "R3 address forced", v, a1 & 32'h0FFF_FFFC);
    finish_xfer("rd0 ok", CC_OK, 1'b0, 1'b1, 32'hCAFE_0001);

    // R4 R2: Type1 write with window bypass, write completion keeps read data (R7)
    set_link(1, 1, 0, CC_OK, 1'b0, 32'hBAD0_BAD0);
    launch(4'hB, (32'd7 << 20) | 32'h0C2, 32'h1234_0000, 4'b1100, 1'b1, 0, 1);
    finish_xfer("wr1 ok", CC_OK, 1'b0, 1'b1, 32'hCAFE_0001);

    // R6 R7: retry status on a read
    set_link(0, 0, 0, CC_CRS, 1'b0, 32'h0000_DEAD);
    launch(4'h9, (32'd2 << 20) | 32'h004, 32'h0, 4'h1, 1'b0, 0, 1);
    finish_xfer("rd crs", CC_CRS, 1'b0, 1'b1, 32'hCAFE_0001);

    // R6 R7: OK code with error flag
    set_link(0, 0, 0, CC_OK, 1'b1, 32'h0000_BEEF);
    launch(4'h8, 32'h0000_0040, 32'h0, 4'h0, 1'b0, 0, 1);
    finish_xfer("rd ok+err", CC_OK, 1'b1, 1'b1, 32'hCAFE_0001);

    // R6: completer abort, unsupported request codes from link
    set_link(0, 0, 0, CC_CA, 1'b0, 32'h0);
    launch(4'hA, 32'h0000_0008, 32'hA5A5_A5A5, 4'hF, 1'b0, 0, 1);
    finish_xfer("wr ca", CC_CA, 1'b0, 1'b1, 32'hCAFE_0001);
    set_link(0, 0, 0, CC_UR, 1'b0, 32'h0);
    launch(4'h8, 32'h0000_0008, 32'h0, 4'hF, 1'b0, 0, 1);
    finish_xfer("rd ur", CC_UR, 1'b0, 1'b1, 32'hCAFE_0001);

    // R8: second start while busy
    set_link(0, 20, 0, CC_OK, 1'b0, 32'h55AA_55AA);
    launch(4'h8, 32'h0010_0000, 32'h0, 4'hF, 1'b0, 0, 1);
    wr(RA_START, 32'd1);
    rd(RA_START, v); chk(v == 1, "R8 start stays set", v, 1);
    finish_xfer("busy start", CC_OK, 1'b0, 1'b1, 32'h55AA_55AA);

    // R9: interrupt status write-one-to-clear
    wr(RA_ISR, 32'd0);
    rd(RA_ISR, v); chk(v == 1, "R9 write 0 keeps isr", v, 1);
    wr(RA_ISR, 32'd1);
    rd(RA_ISR, v); chk(v == 0, "R9 write 1 clears isr", v, 0);
    chk(!irq, "R9 irq dropped", {31'd0, irq}, 0);

    // R10: timeout while waiting for the response
    set_link(0, 0, 1, CC_OK, 1'b0, 32'h0);
    launch(4'h8, 32'h0000_0100, 32'h0, 4'hF, 1'b0, 6, 1);
    finish_xfer("R10 rsp timeout", CC_CA, 1'b1, 1'b1, 32'h55AA_55AA);

    // R10: timeout while the request is never accepted
    set_link(40, 0, 0, CC_OK, 1'b0, 32'h0);
    launch(4'h9, 32'h0020_0000, 32'h0, 4'hF, 1'b0, 5, 0);
    finish_xfer("R10 req timeout", CC_CA, 1'b1, 1'b1, 32'h55AA_55AA);
    repeat (45) @(negedge clk);
    chk(exp_q.size() == 0 && !req_valid, "R10 no late request", {31'd0, req_valid}, 0);

    // R10: limit 0 disables the timeout
    set_link(0, 60, 0, CC_OK, 1'b0, 32'h7777_0000);
    launch(4'h8, 32'h0000_0200, 32'h0, 4'hF, 1'b0, 0, 1);
    repeat (40) @(negedge clk);
    rd(RA_START, v); chk(v == 1, "R10 no timeout when limit 0", v, 1);
    finish_xfer("R10 limit0", CC_OK, 1'b0, 1'b1, 32'h7777_0000);

    // R11: unsupported transaction type
    set_link(0, 0, 0, CC_OK, 1'b0, 32'h0);
    launch(4'h4, 32'h0000_0300, 32'h0, 4'hF, 1'b0, 0, 0);
    finish_xfer("R11 bad type", CC_UR, 1'b0, 1'b0, 32'h7777_0000);

    repeat (5) @(negedge clk);
    report();
  end
endmodule